// File: doc/BRIEF.md
# Multi-Lane Serial Flash Slave Front-End

This block is the serial edge of a flash-memory slave. It oversamples the serial clock, chip-select, pause input and four data pins on a fast system clock. Each transaction is framed by chip-select. A single-lane opcode comes first, then, when the opcode asks for one, a single-lane 24-bit address. After that comes a data phase that runs on one, two or four lanes. The block hands the back-end a strobed opcode, a strobed address and a stream of strobed write bytes. On read commands it asks the back-end for bytes one at a time and shifts them out on the lanes the command uses.

The block drives the four data pins as separate value and enable vectors, so the pad ring can build the bidirectional buffers. The two upper pins serve as data lanes only when the quad-enable configuration input is high. When quad-enable is low, the pause (hold) input can freeze the serial exchange in the middle of a transaction without deselecting the slave. Clock modes 0 and 3 are both accepted. All inputs pass through a synchronizer of `SYNC_STAGES` flops. The serial clock half period must therefore be at least `SYNC_STAGES + 4` system clocks.

Top module: `mio_flash_fe`

## Requirements
- R1: While chip-select (`cs_ni`) is high, and out of reset, all four pin enables are 0 and no opcode, address or write strobe is produced.
- R2: The first 8 bits sampled on `io_i[0]` at SCK rising edges after chip-select falls form the opcode, most significant bit first. It is presented on `op_o` with a one-cycle `op_valid_o` strobe.
- R3: Only opcodes 0x03, 0x3B, 0x6B (reads) and 0x02, 0xA2, 0x32 (writes) take an address. It is the next 24 bits on `io_i[0]`, most significant bit first, strobed once on `addr_valid_o`. Any other opcode goes straight to a single-lane write data phase with no address strobe.
- R4: Write data is sampled at rising edges, most significant bits first. Opcode 0xA2 takes 2 bits per edge, with `io_i[1]` carrying the higher bit. Opcode 0x32 (quad-enable high) takes 4 bits per edge, `io_i[3]` highest. All other write opcodes take 1 bit per edge on `io_i[0]`. Each complete byte gives a one-cycle `wr_valid_o` with `wr_data_o`.
- R5: Read data is launched on SCK falling edges, most significant bits first. Opcode 0x03 uses `io_o[1]`. Opcode 0x3B uses `io_o[1]` (higher bit) and `io_o[0]`. Opcode 0x6B with quad-enable high uses `io_o[3]` down to `io_o[0]`. Bytes are taken from `rd_data_i` in the order of the `rd_req_o` pulses, each valid the cycle after its request, with the first request made as the address completes.
- R6: Transactions behave identically whether SCK idles low (mode 0) or high (mode 3) at the chip-select edges.
- R7: With `qe_i` low, opcodes 0x6B and 0x32 run their data phase on a single lane, and `io_oe_o[3:2]` stay 0.
- R8: Pin enables are nonzero only in the data phase of a read. They are then 4'b0010 for a single lane, 4'b0011 for two lanes and 4'b1111 for four lanes.
- R9: Chip-select rising mid-byte discards the partial byte with no strobe, and the next selection starts again at the opcode.
- R10: With `qe_i` low, `hold_ni` low while selected and SCK low starts a pause. In a pause, SCK edges and data inputs are ignored, enables are 0 and the output shifter is frozen. The exchange resumes where it stopped once `hold_ni` is high with SCK low.
- R11: With `qe_i` high, `hold_ni` has no effect: edges during a low `hold_ni` are taken as data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the serial pins |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock |
| cs_ni | input | 1 | Chip-select, active low |
| hold_ni | input | 1 | Pause request, active low |
| qe_i | input | 1 | Quad-enable configuration bit |
| io_i | input | 4 | Data pin input values |
| io_o | output | 4 | Data pin output values |
| io_oe_o | output | 4 | Data pin output enables |
| op_o | output | 8 | Received opcode |
| op_valid_o | output | 1 | Opcode strobe |
| addr_o | output | ADDR_W | Received address |
| addr_valid_o | output | 1 | Address strobe |
| wr_data_o | output | 8 | Received write byte |
| wr_valid_o | output | 1 | Write byte strobe |
| rd_req_o | output | 1 | Request for the next read byte |
| rd_data_i | input | 8 | Read byte, valid the cycle after its request |

## Verification
The assertions assume the SCK half period is well above the synchronizer delay. They also assume `qe_i` changes only while chip-select is high, and that a pause starts and ends only with SCK low. The bench drives every pin change on the falling system clock edge. It holds each SCK level for eight system clocks and changes quad-enable only between transactions. It moves `hold_ni` only after it has parked SCK low. Random transactions draw opcode, clock mode, quad-enable, address, data and length. Directed runs cover mid-byte and mid-opcode deselection and pauses in both reads and writes.

// File: rtl/mio_fe_pkg.sv
package mio_fe_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {LANE1 = 2'd0, LANE2 = 2'd1, LANE4 = 2'd2} lane_e;
  typedef enum logic [1:0] {PH_OP = 2'd0, PH_ADDR = 2'd1, PH_DATA = 2'd2} phase_e;

  typedef struct packed {
    logic  has_addr;
    logic  is_read;
    lane_e lanes;
  } cmd_t;

  localparam logic [7:0] OP_RD1 = 8'h03;
  localparam logic [7:0] OP_RD2 = 8'h3B;
  localparam logic [7:0] OP_RD4 = 8'h6B;
  localparam logic [7:0] OP_WR1 = 8'h02;
  localparam logic [7:0] OP_WR2 = 8'hA2;
  localparam logic [7:0] OP_WR4 = 8'h32;

  function automatic cmd_t decode_cmd(logic [7:0] op, logic qe);
    cmd_t c;
    c = '{has_addr: 1'b0, is_read: 1'b0, lanes: LANE1};
    case (op)
      OP_RD1: c = '{has_addr: 1'b1, is_read: 1'b1, lanes: LANE1};
      OP_RD2: c = '{has_addr: 1'b1, is_read: 1'b1, lanes: LANE2};
      OP_RD4: c = '{has_addr: 1'b1, is_read: 1'b1, lanes: qe ? LANE4 : LANE1};
      OP_WR1: c = '{has_addr: 1'b1, is_read: 1'b0, lanes: LANE1};
      OP_WR2: c = '{has_addr: 1'b1, is_read: 1'b0, lanes: LANE2};
      OP_WR4: c = '{has_addr: 1'b1, is_read: 1'b0, lanes: qe ? LANE4 : LANE1};
      default: ;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/mio_fe_sync.sv
module mio_fe_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] pipe [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) pipe[g] <= RST_VAL;
        else         pipe[g] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) pipe[g] <= RST_VAL;
        else         pipe[g] <= pipe[g-1];
    end
  end

  assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/mio_fe_hold.sv
module mio_fe_hold (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic hold_ni,
  input  logic qe_i,
  output logic hold_o
);
  // pause state may only change while SCK is low
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)          hold_o <= 1'b0;
    else if (cs_ni | qe_i) hold_o <= 1'b0;
    else if (!sck_i)      hold_o <= !hold_ni;
endmodule

// File: rtl/mio_fe_rx.sv
module mio_fe_rx
  import mio_fe_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              qe_i,
  input  logic              rise_i,
  input  logic [3:0]        io_i,
  output logic [7:0]        op_o,
  output logic              op_valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              addr_valid_o,
  output logic [7:0]        wr_data_o,
  output logic              wr_valid_o,
  output logic              rd_phase_o,
  output lane_e             lanes_o,
  output logic              rd_start_o
);
  localparam int CNT_W = $clog2(ADDR_W);

  phase_e            phase_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic [2:0]        grp_cnt_q;
  logic [7:0]        op_sh_q, in_sh_q;
  logic [ADDR_W-1:0] addr_sh_q;
  logic              is_read_q;
  logic [7:0]        op_nxt, in_nxt;
  logic [ADDR_W-1:0] addr_nxt;
  logic [2:0]        grp_last;
  cmd_t              cmd;

  always_comb begin
    op_nxt   = {op_sh_q[6:0], io_i[0]};
    addr_nxt = {addr_sh_q[ADDR_W-2:0], io_i[0]};
    cmd      = decode_cmd(op_nxt, qe_i);
    case (lanes_o)
      LANE2:   begin in_nxt = {in_sh_q[5:0], io_i[1:0]}; grp_last = 3'd3; end
      LANE4:   begin in_nxt = {in_sh_q[3:0], io_i[3:0]}; grp_last = 3'd1; end
      default: begin in_nxt = {in_sh_q[6:0], io_i[0]};   grp_last = 3'd7; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q      <= PH_OP;
      bit_cnt_q    <= '0;
      grp_cnt_q    <= '0;
      op_sh_q      <= '0;
      in_sh_q      <= '0;
      addr_sh_q    <= '0;
      is_read_q    <= 1'b0;
      lanes_o      <= LANE1;
      op_o         <= '0;
      op_valid_o   <= 1'b0;
      addr_o       <= '0;
      addr_valid_o <= 1'b0;
      wr_data_o    <= '0;
      wr_valid_o   <= 1'b0;
      rd_start_o   <= 1'b0;
    end else begin
      op_valid_o   <= 1'b0;
      addr_valid_o <= 1'b0;
      wr_valid_o   <= 1'b0;
      rd_start_o   <= 1'b0;
      if (cs_ni) begin
        phase_q   <= PH_OP;
        bit_cnt_q <= '0;
        grp_cnt_q <= '0;
        is_read_q <= 1'b0;
        lanes_o   <= LANE1;
      end else if (rise_i) begin
        case (phase_q)
          PH_OP: begin
            op_sh_q <= op_nxt;
            if (bit_cnt_q == CNT_W'(7)) begin
              bit_cnt_q  <= '0;
              op_o       <= op_nxt;
              op_valid_o <= 1'b1;
              is_read_q  <= cmd.is_read;
              lanes_o    <= cmd.lanes;
              phase_q    <= cmd.has_addr ? PH_ADDR : PH_DATA;
            end else begin
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end
          end
          PH_ADDR: begin
            addr_sh_q <= addr_nxt;
            if (bit_cnt_q == CNT_W'(ADDR_W-1)) begin
              bit_cnt_q    <= '0;
              addr_o       <= addr_nxt;
              addr_valid_o <= 1'b1;
              rd_start_o   <= is_read_q;
              phase_q      <= PH_DATA;
            end else begin
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end
          end
          PH_DATA: begin
            if (!is_read_q) begin
              in_sh_q <= in_nxt;
              if (grp_cnt_q == grp_last) begin
                grp_cnt_q  <= '0;
                wr_data_o  <= in_nxt;
                wr_valid_o <= 1'b1;
              end else begin
                grp_cnt_q <= grp_cnt_q + 1'b1;
              end
            end
          end
          default: phase_q <= PH_OP;
        endcase
      end
    end
  end

  assign rd_phase_o = (phase_q == PH_DATA) && is_read_q;
endmodule

// File: rtl/mio_fe_tx.sv
module mio_fe_tx
  import mio_fe_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_ni,
  input  logic       hold_i,
  input  logic       fall_i,
  input  logic       rd_phase_i,
  input  lane_e      lanes_i,
  input  logic       rd_start_i,
  input  logic [7:0] rd_data_i,
  output logic       rd_req_o,
  output logic [3:0] io_o,
  output logic [3:0] oe_o
);
  logic [7:0] out_sh_q, rd_buf_q, shifted;
  logic [2:0] slot_q, slot_last;
  logic       req_d_q, launch;
  logic [3:0] lane_mask;

  assign launch = fall_i && rd_phase_i;

  always_comb begin
    case (lanes_i)
      LANE2: begin
        shifted = {out_sh_q[5:0], 2'b00}; slot_last = 3'd3;
        io_o = {2'b00, out_sh_q[7:6]};     lane_mask = 4'b0011;
      end
      LANE4: begin
        shifted = {out_sh_q[3:0], 4'h0};  slot_last = 3'd1;
        io_o = out_sh_q[7:4];              lane_mask = 4'b1111;
      end
      default: begin
        shifted = {out_sh_q[6:0], 1'b0};  slot_last = 3'd7;
        io_o = {2'b00, out_sh_q[7], 1'b0}; lane_mask = 4'b0010;
      end
    endcase
    oe_o = (rd_phase_i && !hold_i && !cs_ni) ? lane_mask : 4'h0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_sh_q <= '0;
      rd_buf_q <= '0;
      slot_q   <= '0;
      rd_req_o <= 1'b0;
      req_d_q  <= 1'b0;
    end else begin
      // a load consumes the buffer and prefetches the following byte
      rd_req_o <= rd_start_i || (launch && slot_q == 3'd0);
      req_d_q  <= rd_req_o;
      if (req_d_q) rd_buf_q <= rd_data_i;
      if (cs_ni) begin
        slot_q <= '0;
      end else if (launch) begin
        out_sh_q <= (slot_q == 3'd0) ? rd_buf_q : shifted;
        slot_q   <= (slot_q == slot_last) ? 3'd0 : slot_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mio_flash_fe.sv
module mio_flash_fe
  import mio_fe_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              cs_ni,
  input  logic              hold_ni,
  input  logic              qe_i,
  input  logic [3:0]        io_i,
  output logic [3:0]        io_o,
  output logic [3:0]        io_oe_o,
  output logic [7:0]        op_o,
  output logic              op_valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              addr_valid_o,
  output logic [7:0]        wr_data_o,
  output logic              wr_valid_o,
  output logic              rd_req_o,
  input  logic [7:0]        rd_data_i
);
  localparam int SYNC_W = 7;

  logic [SYNC_W-1:0] pins_s;
  logic       sck_s, cs_s, hold_n_s, sck_q, hold_act;
  logic [3:0] io_s;
  logic       rise, fall, rd_phase, rd_start;
  lane_e      lanes;

  mio_fe_sync #(
    .W(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(7'b0110000)
  ) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .d_i({sck_i, cs_ni, hold_ni, io_i}), .q_o(pins_s)
  );
  assign {sck_s, cs_s, hold_n_s, io_s} = pins_s;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sck_q <= 1'b0;
    else         sck_q <= sck_s;

  mio_fe_hold u_hold (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_s), .sck_i(sck_s),
    .hold_ni(hold_n_s), .qe_i(qe_i), .hold_o(hold_act)
  );

  assign rise = sck_s && !sck_q && !cs_s && !hold_act;
  assign fall = !sck_s && sck_q && !cs_s && !hold_act;

  mio_fe_rx #(.ADDR_W(ADDR_W)) u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_s), .qe_i(qe_i),
    .rise_i(rise), .io_i(io_s),
    .op_o(op_o), .op_valid_o(op_valid_o),
    .addr_o(addr_o), .addr_valid_o(addr_valid_o),
    .wr_data_o(wr_data_o), .wr_valid_o(wr_valid_o),
    .rd_phase_o(rd_phase), .lanes_o(lanes), .rd_start_o(rd_start)
  );

  mio_fe_tx u_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_s), .hold_i(hold_act),
    .fall_i(fall), .rd_phase_i(rd_phase), .lanes_i(lanes),
    .rd_start_i(rd_start), .rd_data_i(rd_data_i),
    .rd_req_o(rd_req_o), .io_o(io_o), .oe_o(io_oe_o)
  );
endmodule

// File: rtl/mio_flash_fe_chk.sv
module mio_flash_fe_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_s_i,
  input logic       hold_i,
  input logic       qe_i,
  input logic [3:0] io_o,
  input logic [3:0] io_oe_o,
  input logic       op_valid_o,
  input logic       addr_valid_o,
  input logic       wr_valid_o,
  input logic       rd_req_o
);
  // R1
  desel_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s_i |=> !(op_valid_o || addr_valid_o || wr_valid_o));
  // R2
  op_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_o |=> !op_valid_o);
  // R3
  addr_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_o |=> !addr_valid_o);
  // R5
  rd_req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |=> !rd_req_o);
  // R7
  no_quad_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !qe_i |-> (io_oe_o[3:2] == 2'b00));
  // R8
  oe_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_oe_o == 4'h0) || (io_oe_o == 4'h2) || (io_oe_o == 4'h3) || (io_oe_o == 4'hF));
  // R10
  hold_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> ($stable(io_o) && !op_valid_o && !addr_valid_o && !wr_valid_o));
endmodule

bind mio_flash_fe mio_flash_fe_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_s_i(cs_s), .hold_i(hold_act),
  .qe_i(qe_i), .io_o(io_o), .io_oe_o(io_oe_o), .op_valid_o(op_valid_o),
  .addr_valid_o(addr_valid_o), .wr_valid_o(wr_valid_o), .rd_req_o(rd_req_o)
);

// File: tb/mio_flash_fe_test.sv
module mio_flash_fe_test;
  localparam int CLK_PERIOD = 10;
  localparam int H = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, hold_n = 1'b1, qe = 1'b0;
  logic [3:0] io_i = '0, io_o, io_oe_o;
  logic [7:0] op_o, wr_data_o, rd_data_i;
  logic [23:0] addr_o;
  logic op_valid_o, addr_valid_o, wr_valid_o, rd_req_o;

  int n_chk = 0, n_bad = 0, n_op = 0, n_addr = 0, n_wr = 0, rd_idx = 0;
  logic [7:0]  op_seen = '0, rd_base = '0;
  logic [23:0] addr_seen = '0;
  logic [7:0]  wr_log [256];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mio_flash_fe uut (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .cs_ni(cs_n), .hold_ni(hold_n),
    .qe_i(qe), .io_i(io_i), .io_o(io_o), .io_oe_o(io_oe_o),
    .op_o(op_o), .op_valid_o(op_valid_o), .addr_o(addr_o),
    .addr_valid_o(addr_valid_o), .wr_data_o(wr_data_o), .wr_valid_o(wr_valid_o),
    .rd_req_o(rd_req_o), .rd_data_i(rd_data_i)
  );

  function automatic logic [7:0] rd_model(logic [7:0] base, int k);
    return base ^ 8'(k * 29 + 7);
  endfunction

  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin rd_data_i <= '0; rd_idx = 0; end
    else if (cs_n) rd_idx = 0;
    else if (rd_req_o) begin rd_data_i <= rd_model(rd_base, rd_idx); rd_idx++; end

  always @(posedge clk)
    if (rst_n) begin
      if (op_valid_o)   begin op_seen = op_o; n_op++; end
      if (addr_valid_o) begin addr_seen = addr_o; n_addr++; end
      if (wr_valid_o)   begin wr_log[n_wr % 256] = wr_data_o; n_wr++; end
    end

  function automatic int lanes_of(logic [7:0] op, bit q);
    case (op)
      8'h3B, 8'hA2: return 2;
      8'h6B, 8'h32: return q ? 4 : 1;
      default:      return 1;
    endcase
  endfunction
  function automatic bit has_addr(logic [7:0] op);
    return op inside {8'h03, 8'h3B, 8'h6B, 8'h02, 8'hA2, 8'h32};
  endfunction
  function automatic bit is_rd(logic [7:0] op);
    return op inside {8'h03, 8'h3B, 8'h6B};
  endfunction
  function automatic logic [3:0] oe_exp(int l);
    return (l == 4) ? 4'hF : (l == 2) ? 4'h3 : 4'h2;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_h(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic grp(input logic [3:0] d, output logic [3:0] s, output logic [3:0] e);
    sck = 1'b0; io_i = d; wait_h(H);
    s = io_o; e = io_oe_o;
    sck = 1'b1; wait_h(H);
  endtask

  task automatic send_bits(input logic [31:0] v, input int n);
    logic [3:0] s, e;
    for (int i = n - 1; i >= 0; i--) grp({3'b000, v[i]}, s, e);
  endtask

  task automatic send_data(input logic [7:0] b, input int l);
    logic [3:0] s, e;
    if (l == 4)      for (int g = 1; g >= 0; g--) grp(b[g*4 +: 4], s, e);
    else if (l == 2) for (int g = 3; g >= 0; g--) grp({2'b00, b[g*2 +: 2]}, s, e);
    else             send_bits({24'h0, b}, 8);
  endtask

  task automatic recv(input int l, output logic [7:0] got, output bit oebad);
    logic [3:0] s, e;
    got = '0; oebad = 0;
    for (int g = 0; g < 8 / l; g++) begin
      grp(4'h0, s, e);
      if (e != oe_exp(l)) oebad = 1;
      if (l == 4)      got = {got[3:0], s};
      else if (l == 2) got = {got[5:0], s[1:0]};
      else             got = {got[6:0], s[1]};
    end
  endtask

  task automatic sel(input bit m3);
    sck = m3; io_i = '0; wait_h(H);
    cs_n = 1'b0; wait_h(H);
  endtask

  task automatic desel(input bit m3);
    if (!m3) sck = 1'b0;
    wait_h(H);
    cs_n = 1'b1; wait_h(2 * H);
    sck = m3; wait_h(H);
  endtask

  // parks SCK low, pauses, toggles SCK twice carrying t1 then t2 on io0
  task automatic hold_win(input logic t1, input logic t2, output logic [3:0] oe_mid);
    sck = 1'b0; wait_h(H);
    hold_n = 1'b0; wait_h(H);
    oe_mid = io_oe_o;
    io_i = {3'b000, t1}; wait_h(H); sck = 1'b1; wait_h(H); sck = 1'b0; wait_h(H);
    io_i = {3'b000, t2}; wait_h(H); sck = 1'b1; wait_h(H); sck = 1'b0; wait_h(H);
    oe_mid = oe_mid | io_oe_o;
    hold_n = 1'b1; wait_h(H);
  endtask

  task automatic run_xfer(input bit m3, input logic [7:0] op, input bit q,
                          input logic [23:0] a, input int nb);
    int l, op0, ad0, wr0;
    logic [7:0] exp_b [8];
    logic [7:0] got;
    bit oebad;
    string tr;
    qe = q; l = lanes_of(op, q);
    op0 = n_op; ad0 = n_addr; wr0 = n_wr;
    rd_base = 8'($urandom);
    tr = (!q && (op == 8'h6B || op == 8'h32)) ? "R7" : (m3 ? "R6" : "R5");
    sel(m3);
    send_bits({24'h0, op}, 8);
    chk(n_op == op0 + 1 && op_seen == op, "R2 opcode", {24'h0, op_seen}, {24'h0, op});
    if (has_addr(op)) begin
      send_bits({8'h0, a}, 24);
      chk(n_addr == ad0 + 1 && addr_seen == a, "R3 address", {8'h0, addr_seen}, {8'h0, a});
    end else begin
      chk(n_addr == ad0, "R3 no address", n_addr, ad0);
    end
    if (is_rd(op)) begin
      for (int k = 0; k < nb; k++) begin
        recv(l, got, oebad);
        chk(got == rd_model(rd_base, k), {tr, " read byte"}, {24'h0, got}, {24'h0, rd_model(rd_base, k)});
        chk(!oebad, "R8 read enables", {28'h0, io_oe_o}, {28'h0, oe_exp(l)});
      end
    end else begin
      for (int k = 0; k < nb; k++) begin
        exp_b[k] = 8'($urandom);
        send_data(exp_b[k], l);
      end
      chk(n_wr == wr0 + nb, "R4 write count", n_wr - wr0, nb);
      for (int k = 0; k < nb; k++)
        chk(wr_log[(wr0 + k) % 256] == exp_b[k], (tr == "R5") ? "R4 write byte" : {tr, " write byte"},
            {24'h0, wr_log[(wr0 + k) % 256]}, {24'h0, exp_b[k]});
    end
    desel(m3);
    chk(io_oe_o == 4'h0, "R1 deselected enables", {28'h0, io_oe_o}, 0);
  endtask

  initial begin
    int op0, wr0;
    logic [7:0] b, got;
    logic [3:0] s, e, oe_mid;
    logic [7:0] ops [7];
    void'($urandom(32'd1234));
    ops = '{8'h03, 8'h3B, 8'h6B, 8'h02, 8'hA2, 8'h32, 8'h77};
    wait_h(4); rst_n = 1'b1; wait_h(4);
    chk(io_oe_o == 4'h0 && !rd_req_o, "R1 reset enables", {27'h0, rd_req_o, io_oe_o}, 0);
    chk(n_op == 0 && n_wr == 0, "R1 reset strobes", n_op + n_wr, 0);

    run_xfer(0, 8'h03, 0, 24'h12_3456, 3);
    run_xfer(1, 8'h03, 0, 24'hA5_5A00, 2);
    run_xfer(0, 8'h3B, 0, 24'h00_00FF, 3);
    run_xfer(1, 8'h6B, 1, 24'hFF_FFFF, 3);
    run_xfer(0, 8'h6B, 0, 24'h80_0001, 2);
    run_xfer(0, 8'h02, 0, 24'h01_0203, 3);
    run_xfer(1, 8'hA2, 0, 24'h55_AA55, 3);
    run_xfer(0, 8'h32, 1, 24'h7F_FFFE, 3);
    run_xfer(1, 8'h32, 0, 24'h00_0000, 2);
    run_xfer(0, 8'h77, 0, 24'h0, 2);

    // R9: abort mid data byte, then mid opcode
    qe = 0; wr0 = n_wr;
    sel(0); send_bits(32'h02, 8); send_bits(32'h000100, 24); send_bits(32'h5, 3); desel(0);
    chk(n_wr == wr0, "R9 partial byte dropped", n_wr - wr0, 0);
    op0 = n_op;
    sel(1); send_bits(32'h15, 5); desel(1);
    chk(n_op == op0, "R9 partial opcode dropped", n_op - op0, 0);
    run_xfer(0, 8'hA2, 0, 24'h33_4455, 1);

    // R10: pause inside a write byte, toggles ignored
    qe = 0; wr0 = n_wr; b = 8'hC6;
    sel(0); send_bits(32'h02, 8); send_bits(32'h0, 24);
    send_bits({28'h0, b[7:4]}, 4);
    hold_win(~b[3], ~b[3], oe_mid);
    send_bits({28'h0, b[3:0]}, 4);
    chk(n_wr == wr0 + 1 && wr_log[wr0 % 256] == b, "R10 write across pause",
        {24'h0, wr_log[wr0 % 256]}, {24'h0, b});
    desel(0);

    // R10: pause inside a read byte, enables drop and data resumes
    sel(0); send_bits(32'h03, 8); send_bits(32'h000040, 24);
    got = '0;
    for (int g = 0; g < 4; g++) begin grp(4'h0, s, e); got = {got[6:0], s[1]}; end
    hold_win(1'b1, 1'b0, oe_mid);
    chk(oe_mid == 4'h0, "R10 enables off in pause", {28'h0, oe_mid}, 0);
    for (int g = 0; g < 4; g++) begin grp(4'h0, s, e); got = {got[6:0], s[1]}; end
    chk(got == rd_model(rd_base, 0), "R10 read across pause", {24'h0, got}, {24'h0, rd_model(rd_base, 0)});
    desel(0);

    // R11: quad-enable set, pause input ignored
    qe = 1; wr0 = n_wr; b = 8'h9D;
    sel(0); send_bits(32'h02, 8); send_bits(32'h0, 24);
    send_bits({29'h0, b[7:5]}, 3);
    hold_win(b[4], b[3], oe_mid);
    send_bits({29'h0, b[2:0]}, 3);
    chk(n_wr == wr0 + 1 && wr_log[wr0 % 256] == b, "R11 pause ignored",
        {24'h0, wr_log[wr0 % 256]}, {24'h0, b});
    desel(0);

    for (int t = 0; t < 40; t++)
      run_xfer(1'($urandom), ops[$urandom % 7], 1'($urandom), 24'($urandom), 1 + ($urandom % 4));

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule